// File: doc/BRIEF.md
# Interprocessor Mailbox

A register-mapped mailbox that lets several processors trade 32-bit messages. It holds a set of small hardware queues. A processor posts a message by writing a queue's message register, and a processor takes the oldest message by reading the same register. For each queue the block exposes a full indicator and an occupancy count.

Every processor (user) has its own status register, enable mask and interrupt line. For each queue, two events are tracked: "queue holds data" and "queue has space". Status bits are cleared by writing a 1 to them. They come back on the next cycle while the event condition still holds. A user's line stays high while any enabled status bit is set.

The bus is a single-cycle register interface. A read returns data combinationally in the same cycle, and any pop or register update takes effect at the next clock edge. Address bits [1:0] are ignored.

Top module: `mbox_top`

## Requirements
- R1: A write to byte offset 0x040+4*m pushes wdata into queue m. A read of that offset returns the oldest word, and the read pops it, so words leave in the order they were written.
- R2: Offset 0x080+4*m reads 1 when queue m holds DEPTH words and 0 otherwise. A write to a full queue is dropped, and both count and contents stay unchanged.
- R3: Offset 0x0C0+4*m reads the number of queued words, which is 0 exactly when the queue is empty. A message read of an empty queue returns 0 and leaves the queue unchanged.
- R4: Offset 0x000 reads the REVISION parameter.
- R5: Status bit 2*m (new message, queue m) is set in every user's status register in each cycle that follows a cycle in which queue m was non-empty and that status register was not cleared.
- R6: Status bit 2*m+1 (not full, queue m) is set in the same way, driven by queue m having free space.
- R7: For user u, status is at 0x104+0x10*u. Writing 1 to a bit clears it, and the clear wins over R5/R6 in that cycle. Writing 0 leaves the bit unchanged. A read returns the current value.
- R8: Enable-set at 0x108+0x10*u sets every bit written as 1. Enable-clear at 0x10C+0x10*u clears every bit written as 1. Both offsets read the current enable mask.
- R9: irq_o[u] is 1 exactly when user u's status AND enable is nonzero.
- R10: While rst_ni is low, all queues are empty and all status and enable bits are 0.
- R11: Unmapped offsets read 0, and writes to them change nothing. These include 0x004–0x03C, queue indices ≥ NUM_FIFOS, user indices ≥ NUM_USERS, and word 0 of each user block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus access this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 9 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, same cycle |
| irq_o | output | NUM_USERS | Per-user interrupt line |

## Verification
The queue path is driven three ways. Directed fill-to-full and drain-to-empty runs separate correct ordering from off-by-one pointer wrap, and expose dropped-versus-overwritten pushes and empty-pop side effects. Status is then tested with clear-then-reread sequences, where the first read tells clear priority apart from level re-assertion and the second read confirms that a still-true condition comes back. A long seeded random mix of pushes, pops, clears and mask updates over a few queues reaches collisions between events on several users. This tells apart per-user state from shared state and checks every interrupt line each cycle.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int ADDR_W = 9;

  typedef enum logic [2:0] {
    RGN_CTRL = 3'd0,
    RGN_MSG  = 3'd1,
    RGN_FULL = 3'd2,
    RGN_CNT  = 3'd3
  } region_e;

  typedef enum logic [1:0] {
    USEL_NONE   = 2'd0,
    USEL_STATUS = 2'd1,
    USEL_EN_SET = 2'd2,
    USEL_EN_CLR = 2'd3
  } usel_e;
endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] head_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign count_o = cnt_q;
  assign head_o  = empty_o ? '0 : mem_q[rd_q];

  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= wdata_i;
  end

  assert_no_overflow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i) |=> $stable(count_o));
  assert_empty_pop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && pop_i && !push_i) |=> (count_o == '0));
  assert_count_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CW'(DEPTH));
endmodule

// File: rtl/mbox_user_irq.sv
module mbox_user_irq #(
  parameter int NB = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NB-1:0] cond_i,
  input  logic          st_clr_we_i,
  input  logic          en_set_we_i,
  input  logic          en_clr_we_i,
  input  logic [NB-1:0] wdata_i,
  output logic [NB-1:0] status_o,
  output logic [NB-1:0] enable_o,
  output logic          irq_o
);
  logic [NB-1:0] st_q, en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= '0;
      en_q <= '0;
    end else begin
      // clear has priority; level condition re-sets on later cycles
      st_q <= st_clr_we_i ? (st_q & ~wdata_i) : (st_q | cond_i);
      if (en_set_we_i)      en_q <= en_q | wdata_i;
      else if (en_clr_we_i) en_q <= en_q & ~wdata_i;
    end
  end

  assign status_o = st_q;
  assign enable_o = en_q;
  assign irq_o    = |(st_q & en_q);

  assert_level_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !st_clr_we_i |=> ((status_o & $past(cond_i)) == $past(cond_i)));
  assert_w1c_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_clr_we_i |=> ((status_o & $past(wdata_i)) == '0));
  assert_en_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_set_we_i |=> ((enable_o & $past(wdata_i)) == $past(wdata_i)));
  assert_en_clr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_clr_we_i |=> ((enable_o & $past(wdata_i)) == '0));
endmodule

// File: rtl/mbox_top.sv
module mbox_top
  import mbox_pkg::*;
#(
  parameter int          NUM_FIFOS = 8,
  parameter int          NUM_USERS = 3,
  parameter int          DEPTH     = 4,
  parameter logic [31:0] REVISION  = 32'h0001_0200
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [31:0]          wdata_i,
  output logic [31:0]          rdata_o,
  output logic [NUM_USERS-1:0] irq_o
);
  localparam int DW  = 32;
  localparam int NB  = 2 * NUM_FIFOS;
  localparam int CW  = $clog2(DEPTH + 1);
  localparam int FIW = (NUM_FIFOS > 1) ? $clog2(NUM_FIFOS) : 1;
  localparam int UIW = (NUM_USERS > 1) ? $clog2(NUM_USERS) : 1;

  region_e     region;
  usel_e       usel;
  logic [3:0]  fidx, uidx;
  logic        f_ok, u_ok, u_rgn;
  logic [FIW-1:0] fsel;
  logic [UIW-1:0] usel_idx;

  assign region   = region_e'(addr_i[8:6]);
  assign fidx     = addr_i[5:2];
  assign uidx     = addr_i[7:4];
  assign usel     = usel_e'(addr_i[3:2]);
  assign u_rgn    = addr_i[8];
  assign f_ok     = (int'(fidx) < NUM_FIFOS);
  assign u_ok     = u_rgn && (int'(uidx) < NUM_USERS);
  assign fsel     = fidx[FIW-1:0];
  assign usel_idx = uidx[UIW-1:0];

  logic unused_bits;
  assign unused_bits = ^{addr_i[1:0], wdata_i};

  logic [DW-1:0]  head  [NUM_FIFOS];
  logic [CW-1:0]  cnt   [NUM_FIFOS];
  logic [NUM_FIFOS-1:0] full, empty;
  logic [NB-1:0]  cond;
  logic [NB-1:0]  st  [NUM_USERS];
  logic [NB-1:0]  en  [NUM_USERS];

  logic msg_acc;
  assign msg_acc = req_i && !u_rgn && (region == RGN_MSG) && f_ok;

  for (genvar m = 0; m < NUM_FIFOS; m++) begin : g_fifo
    logic hit;
    assign hit = msg_acc && (fidx == 4'(m));
    mbox_fifo #(.DW(DW), .DEPTH(DEPTH)) i_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (hit && we_i),
      .pop_i   (hit && !we_i),
      .wdata_i (wdata_i),
      .head_o  (head[m]),
      .count_o (cnt[m]),
      .full_o  (full[m]),
      .empty_o (empty[m])
    );
    assign cond[2*m]   = !empty[m];
    assign cond[2*m+1] = !full[m];
  end

  for (genvar u = 0; u < NUM_USERS; u++) begin : g_user
    logic wr_hit;
    assign wr_hit = req_i && we_i && u_rgn && (uidx == 4'(u));
    mbox_user_irq #(.NB(NB)) i_irq (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cond_i      (cond),
      .st_clr_we_i (wr_hit && (usel == USEL_STATUS)),
      .en_set_we_i (wr_hit && (usel == USEL_EN_SET)),
      .en_clr_we_i (wr_hit && (usel == USEL_EN_CLR)),
      .wdata_i     (wdata_i[NB-1:0]),
      .status_o    (st[u]),
      .enable_o    (en[u]),
      .irq_o       (irq_o[u])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (u_rgn) begin
      if (u_ok) begin
        unique case (usel)
          USEL_STATUS:             rdata_o = DW'(st[usel_idx]);
          USEL_EN_SET, USEL_EN_CLR: rdata_o = DW'(en[usel_idx]);
          default:                 rdata_o = '0;
        endcase
      end
    end else begin
      unique case (region)
        RGN_CTRL: if (fidx == '0) rdata_o = REVISION;
        RGN_MSG:  if (f_ok) rdata_o = head[fsel];
        RGN_FULL: if (f_ok) rdata_o = DW'(full[fsel]);
        RGN_CNT:  if (f_ok) rdata_o = DW'(cnt[fsel]);
        default:  rdata_o = '0;
      endcase
    end
  end

  assert_irq_low_in_reset_R10: assert property (@(posedge clk_i)
    !rst_ni |-> (irq_o == '0));
  assert_unmapped_read_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (u_rgn && !u_ok) |-> (rdata_o == '0));
endmodule

// File: tb/test_mbox_top.sv
module test_mbox_top;
  localparam int CLK_PERIOD = 10;
  localparam int NF = 8;
  localparam int NU = 3;
  localparam int DEPTH = 4;
  localparam int NB = 2 * NF;
  localparam logic [31:0] REV = 32'h0001_0200;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req, we;
  logic [8:0] addr;
  logic [31:0] wdata, rdata;
  logic [NU-1:0] irq;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbox_top #(.NUM_FIFOS(NF), .NUM_USERS(NU), .DEPTH(DEPTH), .REVISION(REV)) i_mbox_top (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // reference model
  logic [31:0]   mq  [NF][DEPTH];
  int            mc  [NF];
  logic [NB-1:0] mst [NU];
  logic [NB-1:0] men [NU];

  function automatic logic [8:0] a_msg(int m);  return 9'(32'h040 + 4*m); endfunction
  function automatic logic [8:0] a_full(int m); return 9'(32'h080 + 4*m); endfunction
  function automatic logic [8:0] a_cnt(int m);  return 9'(32'h0C0 + 4*m); endfunction
  function automatic logic [8:0] a_st(int u);   return 9'(32'h104 + 16*u); endfunction
  function automatic logic [8:0] a_es(int u);   return 9'(32'h108 + 16*u); endfunction
  function automatic logic [8:0] a_ec(int u);   return 9'(32'h10C + 16*u); endfunction

  function automatic logic [31:0] model_read(logic [8:0] a);
    int w = int'(a) / 4;
    if (a >= 9'h100) begin
      int off = int'(a) - 256;
      int u = off / 16;
      int s = (off % 16) / 4;
      if (u >= NU || s == 0) return 0;
      return (s == 1) ? 32'(mst[u]) : 32'(men[u]);
    end
    if (w == 0) return REV;
    if (w < 16) return 0;
    if ((w % 16) >= NF) return 0;
    if (w < 32) return (mc[w-16] > 0) ? mq[w-16][0] : 32'h0;
    if (w < 48) return (mc[w-32] == DEPTH) ? 32'h1 : 32'h0;
    return 32'(mc[w-48]);
  endfunction

  function automatic string tag_of(logic [8:0] a);
    int w = int'(a) / 4;
    if (a >= 9'h100) begin
      int off = int'(a) - 256;
      if (off / 16 >= NU || (off % 16) < 4) return "R11";
      return ((off % 16) < 8) ? "R7" : "R8";
    end
    if (w == 0) return "R4";
    if (w < 16 || (w % 16) >= NF) return "R11";
    if (w < 32) return "R1";
    if (w < 48) return "R2";
    return "R3";
  endfunction

  task automatic model_step(logic w, logic [8:0] a, logic [31:0] d);
    logic [NB-1:0] cnd;
    for (int m = 0; m < NF; m++) begin
      cnd[2*m]   = (mc[m] > 0);
      cnd[2*m+1] = (mc[m] < DEPTH);
    end
    for (int u = 0; u < NU; u++) begin
      if (w && a == a_st(u))      mst[u] = mst[u] & ~d[NB-1:0];
      else                        mst[u] = mst[u] | cnd;
      if (w && a == a_es(u))      men[u] = men[u] | d[NB-1:0];
      else if (w && a == a_ec(u)) men[u] = men[u] & ~d[NB-1:0];
    end
    for (int m = 0; m < NF; m++) begin
      if (a == a_msg(m)) begin
        if (w && mc[m] < DEPTH) begin
          mq[m][mc[m]] = d;
          mc[m]++;
        end else if (!w && mc[m] > 0) begin
          for (int k = 0; k < DEPTH - 1; k++) mq[m][k] = mq[m][k+1];
          mc[m]--;
        end
      end
    end
  endtask

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s addr=%h got=%h exp=%h", tag, addr, got, exp);
    end
  endtask

  task automatic check_irq();
    logic [NU-1:0] e;
    for (int u = 0; u < NU; u++) e[u] = |(mst[u] & men[u]);
    check("R9 irq", 32'(irq), 32'(e));
  endtask

  // one bus cycle: drive after negedge, check mid-low phase, advance edge
  task automatic op(logic w, logic [8:0] a, logic [31:0] d, string tag = "");
    req = 1'b1; we = w; addr = a; wdata = d;
    #1;
    if (!w) check((tag == "") ? tag_of(a) : tag, rdata, model_read(a));
    check_irq();
    @(posedge clk);
    model_step(w, a, d);
    @(negedge clk);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int sd;
    sd = $urandom(32'd4711);
    for (int m = 0; m < NF; m++) mc[m] = 0;
    for (int u = 0; u < NU; u++) begin mst[u] = '0; men[u] = '0; end
    req = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    // R10: reset state visible through the bus
    req = 1'b1; addr = a_st(0); #1;
    check("R10 status", rdata, 32'h0);
    addr = a_cnt(0); #1;
    check("R10 count", rdata, 32'h0);
    check("R10 irq", 32'(irq), 32'h0);
    rst_ni = 1'b1;
    @(negedge clk);

    op(0, 9'h000, 0, "R4");
    op(0, a_st(0), 0, "R6");              // not-full bits set after reset
    op(1, a_es(0), 32'h0000_FFFF);
    // fill queue 2 past full
    for (int k = 0; k < DEPTH + 1; k++) op(1, a_msg(2), 32'hA000_0000 + k);
    op(0, a_full(2), 0, "R2");
    op(0, a_cnt(2), 0, "R3");
    op(0, a_st(1), 0, "R5");
    op(0, a_st(1), 0, "R6");
    for (int k = 0; k < DEPTH; k++) op(0, a_msg(2), 0, "R1");
    op(0, a_msg(2), 0, "R3");              // empty read returns 0
    op(0, a_cnt(2), 0, "R3");
    op(0, a_full(2), 0, "R2");
    // W1C priority and re-assertion
    op(1, a_st(0), 32'h0000_FFFF);
    op(0, a_st(0), 0, "R7");
    op(0, a_st(0), 0, "R6");
    op(1, a_st(0), 32'h0);
    op(0, a_st(0), 0, "R7");
    op(1, a_ec(0), 32'h0000_5555);
    op(0, a_es(0), 0, "R8");
    op(0, a_ec(0), 0, "R8");
    op(1, a_msg(0), 32'hDEAD_BEEF);
    op(1, a_st(2), 32'h1);
    op(0, a_st(2), 0, "R5");
    op(0, a_st(2), 0, "R5");
    // unmapped
    op(1, 9'h004, 32'hFFFF_FFFF);
    op(1, 9'h060, 32'h1234_5678);
    op(1, 9'h134, 32'hFFFF_FFFF);
    op(0, 9'h004, 0, "R11");
    op(0, 9'h060, 0, "R11");
    op(0, 9'h0E0, 0, "R11");
    op(0, 9'h100, 0, "R11");
    op(0, 9'h134, 0, "R11");
    op(0, a_cnt(0), 0, "R11");

    for (int i = 0; i < 600; i++) begin
      int m = (($urandom % 4) == 0) ? int'($urandom % NF) : int'($urandom % 3);
      int u = int'($urandom % NU);
      case ($urandom % 9)
        0, 1:    op(1, a_msg(m), $urandom);
        2, 3:    op(0, a_msg(m), 0);
        4:       op(0, a_full(m), 0);
        5:       op(0, a_cnt(m), 0);
        6:       op(0, a_st(u), 0);
        7:       op(1, a_st(u), $urandom);
        default: op(1, ($urandom % 2) ? a_es(u) : a_ec(u), $urandom);
      endcase
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule